// File: doc/BRIEF.md
# Microcontroller Boot Control Registers

This block is the host-side control and status register set of an embedded microcontroller. The host uses it to prepare and launch a firmware run and to collect the results. Before launch, the host writes a boot address and two 32-bit mailbox words, and it can also record an application version word. It then issues a start command. The block passes the boot address to the core with a one-cycle run request and shows the core as running. The core can update either mailbox while it runs. When it finishes it raises a halt signal, and the block then shows it as halted again. The host reads the mailboxes to collect the results.

The start command can arrive through one of two registers: the primary control word or an alias of it. A configuration input picks which one is live, and the host can read that choice back as a status bit in the control word. A start written to the register that is not live is dropped, and so is a start issued while the core is running. The core itself is outside the block. It connects through a run request carrying the boot address, per-mailbox write strobes and data, and a halt input.

Host accesses use word offsets: 0 control, 1 control alias, 2 mailbox 0, 3 mailbox 1, 4 boot address, 5 version. In both control words, bit 0 is the start command, bit 4 is the halted status and bit 6 is the alias-select status.

Top module: `mcu_boot_ctrl`

## Requirements
- R1: After a synchronous reset, the halted status is 1, core_run is 0, and reads of both mailboxes, the boot address and the version word return 0.
- R2: A host write to offset 2, 3, 4 or 5 stores the 32-bit word, and a later read returns it. Read data and host_rvalid appear in the cycle after host_rd. Unmapped offsets read as 0.
- R3: A read of offset 0 or offset 1 returns the halted status in bit 4 and the alias-select status in bit 6, with all other bits 0. The alias-select bit follows cfg_alias_en one cycle late.
- R4: When alias-select is 0 and the core is halted, writing 1 in bit 0 of offset 0 raises core_run for exactly one cycle, starting on the clock edge after the write. During that cycle core_vector equals the stored boot address, and the halted status reads 0.
- R5: When alias-select is 1 and the core is halted, writing 1 in bit 0 of offset 1 starts the core as in R4.
- R6: A start written to the control register that alias-select does not pick is ignored: core_run stays 0 and halted stays 1.
- R7: A start issued while the core is running is ignored: no core_run pulse appears.
- R8: A core mailbox write strobe stores the core's data in that mailbox. If the host writes the same mailbox in the same cycle, the core's data wins.
- R9: core_halt while running sets the halted status on the next edge, after which a new start is accepted.
- R10: A write of 0 in bit 0 of a control offset starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host word offset |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| cfg_alias_en | input | 1 | Selects the alias register as the start path |
| core_run | output | 1 | One-cycle run request to the core |
| core_vector | output | DATA_W | Boot address handed to the core |
| core_mbx_wr | input | MBX_N | Per-mailbox core write strobes |
| core_mbx_wdata | input | MBX_N*DATA_W | Core mailbox data, mailbox 0 in the low word |
| core_halt | input | 1 | Core signals it has finished |

## Verification
Start is tried through the primary word and through the alias word, with alias-select at each value. This separates a correctly chosen path from a dropped one, and it shows whether the block swaps or ignores the select. Starts with bit 0 clear and starts issued while the core runs show whether the halted gating and the bit decode are both present. A host write and a core write that hit the same mailbox in the same cycle show which side has priority. A second boot with a different boot address shows that core_vector is sampled at each start rather than held from the first one.

// File: rtl/mcu_boot_ctrl_pkg.sv
package mcu_boot_ctrl_pkg;
  localparam int OFF_CTRL  = 0;
  localparam int OFF_ALIAS = 1;
  localparam int OFF_MBX0  = 2;
  localparam int OFF_BOOT  = 4;
  localparam int OFF_VER   = 5;

  localparam int START_BIT = 0;
  localparam int HALT_BIT  = 4;
  localparam int ALIAS_BIT = 6;
endpackage

// File: rtl/mcu_boot_ctrl_store.sv
module mcu_boot_ctrl_store
  import mcu_boot_ctrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int MBX_N  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_wr,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [DATA_W-1:0]       host_wdata,
  input  logic [MBX_N-1:0]        core_we,
  input  logic [MBX_N*DATA_W-1:0] core_wdata,
  output logic [MBX_N*DATA_W-1:0] mbx_q,
  output logic [DATA_W-1:0]       boot_q,
  output logic [DATA_W-1:0]       ver_q
);

  for (genvar g = 0; g < MBX_N; g++) begin : g_mbx
    logic host_hit;
    assign host_hit = host_wr && (host_addr == ADDR_W'(OFF_MBX0 + g));

    always_ff @(posedge clk) begin
      if (rst)
        mbx_q[g*DATA_W +: DATA_W] <= '0;
      else if (core_we[g])
        mbx_q[g*DATA_W +: DATA_W] <= core_wdata[g*DATA_W +: DATA_W];
      else if (host_hit)
        mbx_q[g*DATA_W +: DATA_W] <= host_wdata;
    end

    AST_CORE_WINS: assert property (@(posedge clk) disable iff (rst)
      core_we[g] |=> mbx_q[g*DATA_W +: DATA_W] == $past(core_wdata[g*DATA_W +: DATA_W])); // R8
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_q <= '0;
      ver_q  <= '0;
    end else if (host_wr) begin
      if (host_addr == ADDR_W'(OFF_BOOT)) boot_q <= host_wdata;
      if (host_addr == ADDR_W'(OFF_VER))  ver_q  <= host_wdata;
    end
  end

endmodule

// File: rtl/mcu_boot_ctrl_seq.sv
module mcu_boot_ctrl_seq
  import mcu_boot_ctrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              cfg_alias_en,
  input  logic              core_halt,
  input  logic [DATA_W-1:0] boot_addr,
  output logic              halted_q,
  output logic              alias_q,
  output logic              run_q,
  output logic [DATA_W-1:0] vector_q
);

  logic sel_hit;
  logic accept;

  assign sel_hit = alias_q ? (host_addr == ADDR_W'(OFF_ALIAS))
                           : (host_addr == ADDR_W'(OFF_CTRL));
  assign accept  = halted_q && host_wr && host_wdata[START_BIT] && sel_hit;

  always_ff @(posedge clk) begin
    alias_q <= cfg_alias_en;
    if (rst) begin
      halted_q <= 1'b1;
      run_q    <= 1'b0;
      vector_q <= '0;
    end else begin
      run_q <= accept;
      if (accept) begin
        halted_q <= 1'b0;
        vector_q <= boot_addr;
      end else if (!halted_q && core_halt) begin
        halted_q <= 1'b1;
      end
    end
  end

  AST_RUN_CLEARS_HALT: assert property (@(posedge clk) disable iff (rst)
    run_q |-> !halted_q); // R4
  AST_RUN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    run_q |=> !run_q); // R4
  AST_RUN_NEEDS_HALTED: assert property (@(posedge clk) disable iff (rst)
    !halted_q |=> !run_q); // R7
  AST_HALT_SETS: assert property (@(posedge clk) disable iff (rst)
    (!halted_q && core_halt) |=> halted_q); // R9
  AST_ZERO_NO_START: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !host_wdata[START_BIT]) |=> !run_q); // R10

endmodule

// File: rtl/mcu_boot_ctrl_rdback.sv
module mcu_boot_ctrl_rdback
  import mcu_boot_ctrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int MBX_N  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_rd,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [DATA_W-1:0]       ctrl_word,
  input  logic [MBX_N*DATA_W-1:0] mbx_q,
  input  logic [DATA_W-1:0]       boot_q,
  input  logic [DATA_W-1:0]       ver_q,
  output logic [DATA_W-1:0]       rdata,
  output logic                    rvalid
);

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (host_addr == ADDR_W'(OFF_CTRL) || host_addr == ADDR_W'(OFF_ALIAS)) sel = ctrl_word;
    if (host_addr == ADDR_W'(OFF_BOOT)) sel = boot_q;
    if (host_addr == ADDR_W'(OFF_VER))  sel = ver_q;
    for (int i = 0; i < MBX_N; i++)
      if (host_addr == ADDR_W'(OFF_MBX0 + i)) sel = mbx_q[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= host_rd;
      if (host_rd) rdata <= sel;
    end
  end

  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> rvalid); // R2

endmodule

// File: rtl/mcu_boot_ctrl.sv
module mcu_boot_ctrl
  import mcu_boot_ctrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int MBX_N  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_wr,
  input  logic                    host_rd,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [DATA_W-1:0]       host_wdata,
  output logic [DATA_W-1:0]       host_rdata,
  output logic                    host_rvalid,
  input  logic                    cfg_alias_en,
  output logic                    core_run,
  output logic [DATA_W-1:0]       core_vector,
  input  logic [MBX_N-1:0]        core_mbx_wr,
  input  logic [MBX_N*DATA_W-1:0] core_mbx_wdata,
  input  logic                    core_halt
);

  logic [MBX_N*DATA_W-1:0] mbx_q;
  logic [DATA_W-1:0]       boot_q;
  logic [DATA_W-1:0]       ver_q;
  logic                    halted_q;
  logic                    alias_q;
  logic [DATA_W-1:0]       ctrl_word;

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[HALT_BIT]  = halted_q;
    ctrl_word[ALIAS_BIT] = alias_q;
  end

  mcu_boot_ctrl_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MBX_N(MBX_N)) u_store (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .core_we(core_mbx_wr), .core_wdata(core_mbx_wdata),
    .mbx_q(mbx_q), .boot_q(boot_q), .ver_q(ver_q)
  );

  mcu_boot_ctrl_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .cfg_alias_en(cfg_alias_en), .core_halt(core_halt),
    .boot_addr(boot_q), .halted_q(halted_q), .alias_q(alias_q),
    .run_q(core_run), .vector_q(core_vector)
  );

  mcu_boot_ctrl_rdback #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MBX_N(MBX_N)) u_rdback (
    .clk(clk), .rst(rst), .host_rd(host_rd), .host_addr(host_addr),
    .ctrl_word(ctrl_word), .mbx_q(mbx_q), .boot_q(boot_q), .ver_q(ver_q),
    .rdata(host_rdata), .rvalid(host_rvalid)
  );

  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    (halted_q && !(host_wr && host_addr == (alias_q ? ADDR_W'(OFF_ALIAS) : ADDR_W'(OFF_CTRL))))
      |=> !core_run); // R6

endmodule

// File: tb/mcu_boot_ctrl_bench.sv
module mcu_boot_ctrl_bench;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam int MN = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          host_wr, host_rd;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_wdata, host_rdata;
  logic          host_rvalid;
  logic          cfg_alias_en;
  logic          core_run;
  logic [DW-1:0] core_vector;
  logic [MN-1:0] core_mbx_wr;
  logic [MN*DW-1:0] core_mbx_wdata;
  logic          core_halt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  mcu_boot_ctrl #(.DATA_W(DW), .ADDR_W(AW), .MBX_N(MN)) u_mcu_boot_ctrl (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .cfg_alias_en(cfg_alias_en), .core_run(core_run),
    .core_vector(core_vector), .core_mbx_wr(core_mbx_wr),
    .core_mbx_wdata(core_mbx_wdata), .core_halt(core_halt)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    host_wr = 1'b1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    host_rd = 1'b1; host_addr = AW'(a);
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rvalid ? host_rdata : 'x;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [DW-1:0] exp);
    logic [DW-1:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic halt_core();
    core_halt = 1'b1;
    @(negedge clk);
    core_halt = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 run idle", {31'b0, core_run}, 32'h0);
    rd_chk("R1 ctrl halted", 0, 32'h10);
    rd_chk("R1 mbx0", 2, 32'h0);
    rd_chk("R1 mbx1", 3, 32'h0);
    rd_chk("R1 boot", 4, 32'h0);
    rd_chk("R1 ver", 5, 32'h0);
  endtask

  task automatic t_regs();
    wr(2, 32'hA5A5_0001);
    wr(3, 32'h5A5A_0002);
    wr(4, 32'h1000_0400);
    wr(5, 32'h0002_0007);
    rd_chk("R2 mbx0", 2, 32'hA5A5_0001);
    rd_chk("R2 mbx1", 3, 32'h5A5A_0002);
    rd_chk("R2 boot", 4, 32'h1000_0400);
    rd_chk("R2 ver", 5, 32'h0002_0007);
    rd_chk("R2 unmapped", 7, 32'h0);
    rd_chk("R3 alias word", 1, 32'h10);
  endtask

  task automatic t_zero_and_wrong();
    wr(0, 32'hFFFF_FFFE);
    chk("R10 no run", {31'b0, core_run}, 32'h0);
    rd_chk("R10 still halted", 0, 32'h10);
    wr(1, 32'h1);
    chk("R6 alias ignored", {31'b0, core_run}, 32'h0);
    rd_chk("R6 still halted", 0, 32'h10);
  endtask

  task automatic t_start_main();
    wr(0, 32'h1);
    chk("R4 run pulse", {31'b0, core_run}, 32'h1);
    chk("R4 vector", core_vector, 32'h1000_0400);
    @(negedge clk);
    chk("R4 pulse ends", {31'b0, core_run}, 32'h0);
    rd_chk("R4 running", 0, 32'h0);
  endtask

  task automatic t_start_running();
    wr(0, 32'h1);
    chk("R7 no run", {31'b0, core_run}, 32'h0);
    @(negedge clk);
    chk("R7 still no run", {31'b0, core_run}, 32'h0);
  endtask

  task automatic t_core_mbx();
    core_mbx_wr = 2'b01;
    core_mbx_wdata = {32'h0, 32'hC0DE_0001};
    host_wr = 1'b1; host_addr = AW'(2); host_wdata = 32'h1111_1111;
    @(negedge clk);
    host_wr = 1'b0;
    core_mbx_wr = 2'b10;
    core_mbx_wdata = {32'hBEEF_0002, 32'h0};
    @(negedge clk);
    core_mbx_wr = 2'b00;
    rd_chk("R8 core wins mbx0", 2, 32'hC0DE_0001);
    rd_chk("R8 core mbx1", 3, 32'hBEEF_0002);
  endtask

  task automatic t_halt();
    halt_core();
    rd_chk("R9 halted again", 0, 32'h10);
    rd_chk("R9 result kept", 3, 32'hBEEF_0002);
  endtask

  task automatic t_alias();
    cfg_alias_en = 1'b1;
    @(negedge clk);
    rd_chk("R3 alias status", 0, 32'h50);
    wr(4, 32'h2000_0800);
    wr(0, 32'h1);
    chk("R6 main ignored", {31'b0, core_run}, 32'h0);
    rd_chk("R6 halted", 1, 32'h50);
    wr(1, 32'h1);
    chk("R5 run pulse", {31'b0, core_run}, 32'h1);
    chk("R5 vector", core_vector, 32'h2000_0800);
    rd_chk("R5 running", 1, 32'h40);
    halt_core();
    rd_chk("R9 halted alias", 1, 32'h50);
  endtask

  initial begin
    rst = 1'b1; host_wr = 1'b0; host_rd = 1'b0; host_addr = '0; host_wdata = '0;
    cfg_alias_en = 1'b0; core_mbx_wr = '0; core_mbx_wdata = '0; core_halt = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_zero_and_wrong();
    t_start_main();
    t_start_running();
    t_core_mbx();
    t_halt();
    t_alias();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule